// File: doc/BRIEF.md
# Coefficient Compress/Decompress Unit

This unit rescales polynomial coefficients of a lattice-based scheme between the full modulus range and a short d-bit code, with the modulus fixed at q = 3329. Each transaction carries a 12-bit coefficient, a 5-bit width d and a direction bit. Compression maps a value from the modulus range onto d bits. Decompression expands a d-bit code back into the modulus range. Both directions scale by a ratio of q to 2^d and round to the nearest integer, with ties going upward.

Transactions enter with `valid_i` and leave one clock later through a single output register with `valid_o`. A two-state controller sits at the output. In state EMPTY, an arriving transaction takes the LOAD transition to FULL. In state FULL there are three transitions. STALL keeps the result frozen while `ready_i` is low. REFILL replaces the result when it is consumed and a new transaction arrives in the same cycle. DRAIN returns to EMPTY when the result is consumed and nothing new arrives. `in_ready` tells the sender whether a transaction offered in the current cycle will be taken.

Top module: `coeff_codec`

## Requirements
- R1: With mode = 0 (compress) and 1 ≤ d ≤ 12, the result is floor((x·2^d + 1664) / 3329) mod 2^d, where x is any 12-bit `coeff_in` value. For example, d = 4 and x = 3328 gives 0.
- R2: Halfway cases round up. With mode = 1, d = 1 and code 1, the exact value 1664.5 gives 1665.
- R3: Compressing x = 3328, which lies just below q, wraps to 0 for every d from 1 to 12 at which the rounded quotient reaches 2^d. For d = 4 the result is 0.
- R4: With mode = 1 (decompress) and 1 ≤ d ≤ 12, the result is floor((y·3329 + 2^(d−1)) / 2^d). Here y is only the low d bits of `coeff_in`, so the upper bits have no effect on the result.
- R5: With d = 12, compression still wraps modulo 4096. The input x = 3329 gives 0.
- R6: A width of d = 0, or any d above 12, gives a result of 0 in both directions.
- R7: A transaction accepted at a rising edge shows `valid_o` = 1 and its result on `coeff_out` right after that edge. With `valid_i` held high and `ready_i` high, one result is produced on every cycle.
- R8: While `valid_o` = 1 and `ready_i` = 0, the values of `valid_o` and `coeff_out` stay unchanged at the next edge.
- R9: `in_ready` = 1 exactly when `valid_o` = 0 or `ready_i` = 1. A transaction offered while `in_ready` = 0 is ignored and does not change `coeff_out`.
- R10: After reset, `valid_o` = 0 and `in_ready` = 1.
- R11: When a result is consumed (`ready_i` = 1) and `valid_i` = 0, `valid_o` goes to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A transaction is offered |
| mode | input | 1 | 0 = compress, 1 = decompress |
| width_d | input | 5 | Code width d for this transaction |
| coeff_in | input | 12 | Coefficient (compress) or code (decompress) |
| in_ready | output | 1 | An offered transaction is taken this cycle |
| ready_i | input | 1 | Downstream consumes the presented result |
| valid_o | output | 1 | A result is presented |
| coeff_out | output | 12 | Result value |

## Verification
A fault in the output controller shows at the ports after one edge. A lost LOAD leaves `valid_o` low where a result is due. A missed STALL changes `coeff_out` under back-pressure. A wrong DRAIN either keeps `valid_o` high after consumption or drops a REFILL result. A fault in the arithmetic corrupts only the result registered for the transaction that exercises it, so the bench runs every 12-bit input through both directions at every legal width. Any bad rounding, tie or wrap case therefore surfaces on the cycle after that input.

// File: rtl/codec_pkg.sv
package codec_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_t;

    function automatic logic [31:0] low_mask(input logic [4:0] d);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) begin
            m[i] = (i < int'(d));
        end
        return m;
    endfunction

endpackage

// File: rtl/codec_compress.sv
module codec_compress
    import codec_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int DW_W   = 5,
    parameter int Q      = 3329
) (
    input  logic [COEF_W-1:0] x,
    input  logic [DW_W-1:0]   d,
    output logic [COEF_W-1:0] y
);
    localparam int PROD_W = 2 * COEF_W + 1;
    localparam logic [PROD_W-1:0] HALF_Q = PROD_W'(Q / 2);
    localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(Q);

    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] quot;
    logic [PROD_W-1:0] wrapped;
    logic              d_ok;

    always_comb begin
        d_ok    = (d != '0) && (int'(d) <= COEF_W);
        scaled  = (PROD_W'(x) << d) + HALF_Q;
        quot    = scaled / DIVISOR;
        wrapped = quot & PROD_W'(low_mask(5'(d)));
        y       = d_ok ? COEF_W'(wrapped) : '0;
    end

endmodule

// File: rtl/codec_decompress.sv
module codec_decompress
    import codec_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int DW_W   = 5,
    parameter int Q      = 3329
) (
    input  logic [COEF_W-1:0] x,
    input  logic [DW_W-1:0]   d,
    output logic [COEF_W-1:0] y
);
    localparam int PROD_W = 2 * COEF_W + 1;
    localparam logic [PROD_W-1:0] MULT = PROD_W'(Q);

    logic [COEF_W-1:0] code;
    logic [PROD_W-1:0] half_step;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;
    logic              d_ok;

    always_comb begin
        d_ok      = (d != '0) && (int'(d) <= COEF_W);
        code      = x & COEF_W'(low_mask(5'(d)));
        half_step = d_ok ? (PROD_W'(1) << (d - DW_W'(1))) : '0;
        prod      = PROD_W'(code) * MULT + half_step;
        shifted   = prod >> d;
        y         = d_ok ? COEF_W'(shifted) : '0;
    end

endmodule

// File: rtl/codec_out_stage.sv
module codec_out_stage
    import codec_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    input  logic         ready_i,
    output logic         in_ready,
    output logic         valid_o,
    output logic [W-1:0] data_o
);
    hold_state_t state_q, state_d;
    logic [W-1:0] data_q;
    logic         take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: LOAD, STALL, REFILL, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (valid_i) state_d = ST_FULL;              // LOAD
            end
            ST_FULL: begin
                if (ready_i && !valid_i) state_d = ST_EMPTY; // DRAIN
                else                     state_d = ST_FULL;  // STALL / REFILL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        valid_o  = (state_q == ST_FULL);
        in_ready = (state_q == ST_EMPTY) || ready_i;
        take     = valid_i && in_ready;
        data_o   = data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take) begin
            data_q <= data_i;
        end
    end

endmodule

// File: rtl/coeff_codec.sv
module coeff_codec #(
    parameter int COEF_W = 12,
    parameter int DW_W   = 5,
    parameter int Q      = 3329
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              mode,
    input  logic [DW_W-1:0]   width_d,
    input  logic [COEF_W-1:0] coeff_in,
    output logic              in_ready,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [COEF_W-1:0] coeff_out
);
    logic [COEF_W-1:0] comp_res;
    logic [COEF_W-1:0] decomp_res;
    logic [COEF_W-1:0] sel_res;

    codec_compress #(.COEF_W(COEF_W), .DW_W(DW_W), .Q(Q)) u_comp (
        .x (coeff_in),
        .d (width_d),
        .y (comp_res)
    );

    codec_decompress #(.COEF_W(COEF_W), .DW_W(DW_W), .Q(Q)) u_decomp (
        .x (coeff_in),
        .d (width_d),
        .y (decomp_res)
    );

    assign sel_res = mode ? decomp_res : comp_res;

    codec_out_stage #(.W(COEF_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .data_i   (sel_res),
        .ready_i  (ready_i),
        .in_ready (in_ready),
        .valid_o  (valid_o),
        .data_o   (coeff_out)
    );

endmodule

// File: rtl/codec_checker.sv
module codec_checker #(
    parameter int COEF_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              ready_i,
    input logic              in_ready,
    input logic              valid_o,
    input logic [COEF_W-1:0] coeff_out
);
    // R8: stalled result is frozen
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(coeff_out)));

    // R7: accepted transaction presents a result next cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && in_ready) |=> valid_o);

    // R11: consumed with nothing new empties the stage
    a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !valid_i) |=> !valid_o);

    // R9: a full stage under back-pressure refuses input
    a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |-> !in_ready);

    // R9: an empty stage always accepts
    a_r9_accept_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> in_ready);
endmodule

bind coeff_codec codec_checker #(.COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .ready_i   (ready_i),
    .in_ready  (in_ready),
    .valid_o   (valid_o),
    .coeff_out (coeff_out)
);

// File: tb/coeff_codec_bench.sv
module coeff_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        mode = 1'b0;
    logic [4:0]  width_d = '0;
    logic [11:0] coeff_in = '0;
    logic        ready_i = 1'b1;
    logic        in_ready;
    logic        valid_o;
    logic [11:0] coeff_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coeff_codec u_coeff_codec (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .mode      (mode),
        .width_d   (width_d),
        .coeff_in  (coeff_in),
        .in_ready  (in_ready),
        .ready_i   (ready_i),
        .valid_o   (valid_o),
        .coeff_out (coeff_out)
    );

    function automatic int ref_val(bit m, int d, int x);
        if (d < 1 || d > 12) return 0;
        if (!m) return (((x << d) + 1664) / 3329) % (1 << d);
        return (((x & ((1 << d) - 1)) * 3329) + (1 << (d - 1))) >> d;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // offer one transaction, step one edge, check output just after it
    task automatic one(string tag, bit m, int d, int x, int exp);
        mode = m; width_d = 5'(d); coeff_in = 12'(x); valid_i = 1'b1;
        @(posedge clk); #1;
        if (!valid_o) chk({tag, " valid"}, 0, 1);
        else          chk(tag, int'(coeff_out), exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 valid_o", int'(valid_o), 0);
        chk("R10 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(posedge clk); #1;

        one("R1 d4 x100", 0, 4, 100, ref_val(0, 4, 100));
        one("R3 d4 x3328 wrap", 0, 4, 3328, 0);
        one("R2 d1 tie", 1, 1, 1, 1665);
        one("R4 upper bits", 1, 4, 12'hFF3, 624);
        one("R4 low only", 1, 4, 12'h003, 624);
        one("R5 d12 x3329 wrap", 0, 12, 3329, 0);
        one("R6 d0 comp", 0, 0, 100, 0);
        one("R6 d0 decomp", 1, 0, 100, 0);
        one("R6 d13 comp", 0, 13, 2000, 0);
        one("R6 d31 decomp", 1, 31, 2000, 0);

        // R7: back-to-back sweep of both directions, every legal width and input
        for (int m = 0; m < 2; m++) begin
            for (int d = 1; d <= 12; d++) begin
                for (int x = 0; x < 4096; x++) begin
                    one(m == 0 ? "R1 sweep" : "R4 sweep", bit'(m), d, x, ref_val(bit'(m), d, x));
                end
            end
        end

        // R11: drain
        valid_i = 1'b0;
        @(posedge clk); #1;
        chk("R11 drained", int'(valid_o), 0);

        // R8 / R9: back-pressure
        ready_i = 1'b0;
        one("R8 load", 1, 10, 513, ref_val(1, 10, 513));
        chk("R9 in_ready low", int'(in_ready), 0);
        for (int k = 0; k < 3; k++) begin
            mode = 1'b0; width_d = 5'd3; coeff_in = 12'd2000; valid_i = 1'b1;
            @(posedge clk); #1;
            chk("R8 valid held", int'(valid_o), 1);
            chk("R9 ignored input", int'(coeff_out), ref_val(1, 10, 513));
        end
        valid_i = 1'b0;
        ready_i = 1'b1;
        #1;
        chk("R9 in_ready high", int'(in_ready), 1);
        @(posedge clk); #1;
        chk("R11 drain after stall", int'(valid_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule